// File: doc/BRIEF.md
# Memory-Based Hardware Sorting Core

This block is a bus-attached accelerator that puts a block of small unsigned values into ascending order. The values are held in an on-chip RAM with a registered (synchronous) read port. A processor reaches the block through a simple register slot. The slot has a 5-bit register address, 32-bit write and read data, and read, write and chip-select strobes.

In use, software first pulses the clear bit so that the load/unload pointer returns to zero. It then writes the values one at a time through the data-in register, sets the start bit, and polls the completion flag. When the flag is set, it drops the start bit, pulses clear again, and reads the sorted values back one at a time through the data-out register.

The sort runs in place as an exchange sort. An outer index walks over every element except the last. An inner index walks over every element after the outer one. Whenever the element at the outer index is larger than the element at the inner index, the two are exchanged. A controller FSM sequences a datapath that holds the two index counters, the operand latches and the RAM.

Top module: `sort_core`

## Requirements
- R1: After reset the completion flag reads 0, the controller is idle, the control register is 0 and the load/unload pointer is 0.
- R2: A bus write with cs high to register 0 (addr[1:0] = 0), while no sort is running, stores wrData[7:0] at the pointer and then advances the pointer by one, wrapping at the element count.
- R3: A bus read with cs high and addr[0] = 0 (register 2) returns, while no sort is running, the element at the pointer in rdData[7:0] and then advances the pointer. Reads in back-to-back cycles return consecutive elements.
- R4: Register 1 (addr[1:0] = 1) is the control register: bit 0 starts the sort, and bit 1 is a clear that holds the pointer at 0 while it is set.
- R5: A sort is started only by the start bit. When it ends, the memory holds the same multiset of values in ascending unsigned order.
- R6: A read with addr[0] = 1 (register 3) returns the completion flag in bit 0. The flag sets only at the end of a sort, stays set while the start bit stays 1, and clears one cycle after the start bit returns to 0.
- R7: rdData bits above the element width always read as zero.
- R8: While a sort runs, data-in writes change neither the memory nor the pointer, and data-out reads leave the pointer unchanged. The memory is written during the sort only by the exchange step.
- R9: Corner orderings sort correctly: input already in order, input in reverse order, many duplicate values, and the extreme values 0 and 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Slot select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 5 | Register address within the slot |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (combinational on addr) |

## Verification
The bench builds the core with a 4-bit index, which gives 16 elements. At that size each full exchange sort finishes in a few hundred cycles, so several complete sorts fit in one run. The orderings covered are random, reverse, already ordered, heavy duplicates, and extremes. At 16 elements the pointer also wraps back to zero after a full load. That wrap lets a stray write or read during a sort show up as a shifted readout when no clear is pulsed before the unload.

// File: rtl/sort_pkg.sv
package sort_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_SETJ, S_RDI, S_RDJ, S_CMP, S_SWAP, S_DONE
  } sortState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic initI;
    logic incI;
    logic setJ;
    logic incJ;
    logic busy;
    logic addrSelJ;
    logic latchA;
    logic latchB;
    logic swapWe;
    logic done;
  } ctrlStrobes_t;

  localparam logic [1:0] OFS_DIN  = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;

endpackage

// File: rtl/sort_datapath.sv
module sort_datapath
  import sort_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  input  ctrlStrobes_t      stb,
  output logic              goLevel,
  output logic              iLast,
  output logic              jLast,
  output logic              aGtB
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_END = IDX_W'(DEPTH - 2);
  localparam logic [IDX_W-1:0] J_END = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memQ;
  logic [DATA_W-1:0] regA, regB;
  logic [IDX_W-1:0]  ptr, ptrNext, iIdx, jIdx, rdAddr;
  logic [1:0]        ctrlReg;
  logic              dataInWr, ctrlWr, dataOutRd;

  // bus decode; data moves only while the controller is not sorting
  assign dataInWr  = cs && wr && (addr[1:0] == OFS_DIN) && !stb.busy;
  assign ctrlWr    = cs && wr && (addr[1:0] == OFS_CTRL);
  assign dataOutRd = cs && rd && !addr[0] && !stb.busy;
  assign goLevel   = ctrlReg[0];

  always_comb begin
    if (ctrlReg[1])                 ptrNext = '0;
    else if (dataInWr || dataOutRd) ptrNext = ptr + 1'b1;
    else                            ptrNext = ptr;
  end

  // read the next pointer so the output register always shows mem[ptr]
  assign rdAddr = stb.busy ? (stb.addrSelJ ? jIdx : iIdx) : ptrNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      ptr     <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= wrData[1:0];
      ptr <= ptrNext;
    end
  end

  // index counters
  always_ff @(posedge clk) begin
    if (rst) begin
      iIdx <= '0;
      jIdx <= '0;
    end else begin
      if (stb.initI)     iIdx <= '0;
      else if (stb.incI) iIdx <= iIdx + 1'b1;
      if (stb.setJ)      jIdx <= iIdx + 1'b1;
      else if (stb.incJ) jIdx <= jIdx + 1'b1;
    end
  end

  assign iLast = (iIdx == I_END);
  assign jLast = (jIdx == J_END);

  // operand latches
  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (stb.latchA) regA <= memQ;
      if (stb.latchB) regB <= memQ;
    end
  end

  assign aGtB = regA > memQ;

  // element storage with registered read
  always_ff @(posedge clk) begin
    if (dataInWr) mem[ptr] <= wrData[DATA_W-1:0];
    if (stb.swapWe) begin
      mem[iIdx] <= regB;
      mem[jIdx] <= regA;
    end
    memQ <= mem[rdAddr];
  end

  always_comb begin
    rdData = '0;
    if (addr[0]) rdData[0] = stb.done;
    else         rdData[DATA_W-1:0] = memQ;
  end

endmodule

// File: rtl/sort_control.sv
module sort_control
  import sort_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         goLevel,
  input  logic         iLast,
  input  logic         jLast,
  input  logic         aGtB,
  output ctrlStrobes_t stb
);

  sortState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (goLevel) stateNext = S_INIT;
      S_INIT: begin
        stb.busy = 1'b1; stb.initI = 1'b1; stateNext = S_SETJ;
      end
      S_SETJ: begin
        stb.busy = 1'b1; stb.setJ = 1'b1; stateNext = S_RDI;
      end
      S_RDI: begin
        stb.busy = 1'b1; stateNext = S_RDJ;
      end
      S_RDJ: begin
        stb.busy = 1'b1; stb.addrSelJ = 1'b1; stb.latchA = 1'b1; stateNext = S_CMP;
      end
      S_CMP, S_SWAP: begin
        stb.busy     = 1'b1;
        stb.addrSelJ = 1'b1;
        if (state == S_CMP) stb.latchB = 1'b1;
        if (state == S_CMP && aGtB) begin
          stateNext = S_SWAP;
        end else begin
          if (state == S_SWAP) stb.swapWe = 1'b1;
          if (!jLast) begin
            stb.incJ = 1'b1; stateNext = S_RDI;
          end else if (!iLast) begin
            stb.incI = 1'b1; stateNext = S_SETJ;
          end else begin
            stateNext = S_DONE;
          end
        end
      end
      S_DONE: begin
        stb.done = 1'b1;
        if (!goLevel) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/sort_core.sv
module sort_core
  import sort_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [4:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData
);

  ctrlStrobes_t stb;
  logic goLevel, iLast, jLast, aGtB;

  sort_datapath #(.IDX_W(IDX_W), .DATA_W(DATA_W), .BUS_W(32), .ADDR_W(5)) u_dp (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wrData(wrData), .rdData(rdData), .stb(stb), .goLevel(goLevel),
    .iLast(iLast), .jLast(jLast), .aGtB(aGtB)
  );

  sort_control u_ctrl (
    .clk(clk), .rst(rst), .goLevel(goLevel), .iLast(iLast),
    .jLast(jLast), .aGtB(aGtB), .stb(stb)
  );

endmodule

// File: rtl/sort_core_checker.sv
module sort_core_checker #(
  parameter int DATA_W = 8
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] rdData,
  input logic        busy,
  input logic        swapWe,
  input logic        doneFlag,
  input logic        goLevel
);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rdData[31:DATA_W] == '0);

  p_swap_in_sort_r8: assert property (@(posedge clk) disable iff (rst)
    swapWe |-> busy);

  p_start_by_go_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(goLevel));

  p_done_after_sort_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> $past(busy));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (doneFlag && goLevel) |=> doneFlag);

  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (doneFlag && !goLevel) |=> !doneFlag);

endmodule

bind sort_core sort_core_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rdData(rdData), .busy(stb.busy),
  .swapWe(stb.swapWe), .doneFlag(stb.done), .goLevel(goLevel)
);

// File: tb/sort_core_bench.sv
module sort_core_bench;
  localparam int IW = 4;
  localparam int N  = 1 << IW;

  logic clk = 0, rst = 1, cs = 0, rd = 0, wr = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  wire  [31:0] rdData;

  int checks = 0, errors = 0;
  logic [7:0]  expQ[$];
  logic [31:0] obsData;
  string       obsTag;
  event        obsEv;
  logic [7:0]  pat [N];
  logic [7:0]  ref_s [N];

  always #4 clk = ~clk;

  sort_core #(.IDX_W(IW), .DATA_W(8)) u_sort_core (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every data-out read
  always @(obsEv) begin
    if (expQ.size() == 0) check(1'b0, {obsTag, " unexpected read"}, obsData, 0);
    else begin
      logic [7:0] e;
      e = expQ.pop_front();
      check(obsData == {24'h0, e}, obsTag, obsData, {24'h0, e});
    end
  end

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wrData = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #2 d = rdData;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic dataRead(input string tag);
    logic [31:0] d;
    busRead(5'd2, d);
    obsData = d; obsTag = tag;
    -> obsEv;
    #0;
  endtask

  task automatic buildRef();
    for (int a = 0; a < N; a++) ref_s[a] = pat[a];
    for (int a = 1; a < N; a++)
      for (int b = a; b > 0 && ref_s[b-1] > ref_s[b]; b--) begin
        logic [7:0] t;
        t = ref_s[b]; ref_s[b] = ref_s[b-1]; ref_s[b-1] = t;
      end
  endtask

  task automatic runSort(input string tag, input bit stray);
    logic [31:0] d;
    int waitCnt;
    busWrite(5'd1, 32'd2); busWrite(5'd1, 32'd0);
    for (int k = 0; k < N; k++) busWrite(5'd0, {24'hFFFFFF, pat[k]});
    buildRef();
    busWrite(5'd1, 32'd1);
    if (stray) begin
      busWrite(5'd0, 32'h000000AA);   // R8: ignored while sorting
      busRead(5'd2, d);               // R8: must not move the pointer
    end
    waitCnt = 0;
    do begin busRead(5'd3, d); waitCnt++; end while (!d[0] && waitCnt < 5000);
    check(d == 32'd1, {tag, " R6 done set"}, d, 1);
    repeat (3) begin
      busRead(5'd3, d);
      check(d == 32'd1, {tag, " R6 done held with go"}, d, 1);
    end
    busWrite(5'd1, 32'd0);
    busRead(5'd3, d);
    check(d == 32'd0, {tag, " R6 done cleared"}, d, 0);
    if (!stray) begin busWrite(5'd1, 32'd2); busWrite(5'd1, 32'd0); end
    for (int k = 0; k < N; k++) expQ.push_back(ref_s[k]);
    for (int k = 0; k < N; k++) dataRead({tag, " R5 R3 sorted readout"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    busRead(5'd3, d);
    check(d == 32'd0, "R1 done after reset", d, 0);
    busRead(5'd1, d);
    check(d == 32'd0, "R1 odd register after reset", d, 0);

    // random with extremes
    for (int k = 0; k < N; k++) pat[k] = 8'($urandom_range(0, 255));
    pat[3] = 8'd0; pat[9] = 8'd255; pat[12] = 8'd128;
    runSort("random R9", 1'b0);

    // R9 reverse order
    for (int k = 0; k < N; k++) pat[k] = 8'((N - 1 - k) * 16 + 7);
    runSort("reverse R9", 1'b0);

    // R9 already ordered
    for (int k = 0; k < N; k++) pat[k] = 8'(k * 9);
    runSort("ordered R9", 1'b0);

    // R9 duplicates
    for (int k = 0; k < N; k++) pat[k] = 8'((k % 3) * 100 + 5);
    runSort("duplicates R9", 1'b0);

    // R8 stray bus traffic during sort, no clear before unload
    for (int k = 0; k < N; k++) pat[k] = 8'(k * 37 + 11);
    runSort("stray R8", 1'b1);

    // R4 clear mid-unload returns pointer to 0
    expQ.push_back(ref_s[0]); expQ.push_back(ref_s[1]); expQ.push_back(ref_s[2]);
    repeat (3) dataRead("R4 partial readout");
    busWrite(5'd1, 32'd2); busWrite(5'd1, 32'd0);
    expQ.push_back(ref_s[0]);
    dataRead("R4 pointer cleared");

    // R2 overwrite from index 0 then read back in order
    busWrite(5'd1, 32'd2); busWrite(5'd1, 32'd0);
    busWrite(5'd0, 32'hABCD125C); busWrite(5'd0, 32'h00000011);
    busWrite(5'd1, 32'd2); busWrite(5'd1, 32'd0);
    expQ.push_back(8'h5C); expQ.push_back(8'h11); expQ.push_back(ref_s[2]);
    repeat (3) dataRead("R2 R7 load and readback");

    // R3 back-to-back reads in consecutive cycles
    busWrite(5'd1, 32'd2); busWrite(5'd1, 32'd0);
    @(negedge clk); cs = 1; rd = 1; addr = 5'd2;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      #2;
      e = (k == 0) ? 8'h5C : (k == 1) ? 8'h11 : ref_s[k];
      check(rdData == {24'h0, e}, "R3 back-to-back read", rdData, {24'h0, e});
      @(negedge clk);
    end
    cs = 0; rd = 0;

    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule